// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller with Flag and Enable Registers

The controller sits beside a processor core and collects interrupt events into sixteen priority slots. Every event source owns a flag bit that hardware raises and an enable bit that software programs. A status register holds a global enable and a low-power bit. Maskable slots may request service only while the global enable is set. The two top slots (15 and 14) are non-maskable: they ignore the global enable but still honour their own per-source enables. Some slots (selected by a parameter) gather two sources. Their request is the OR of both enabled flags, and software is left to clear those flags.

When the core signals an instruction boundary and a slot is requesting, the controller accepts the highest-numbered requesting slot. It saves the status register and clears it, which drops the global enable and leaves low-power mode. It clears the flag when the slot has a single source. It then runs a fixed six-cycle entry sequence and presents the vector address in the last cycle. Vector addresses descend by two bytes per priority step from 0xFFFE (slot 15) to 0xFFE0 (slot 0). A return request from the handler starts a five-cycle exit sequence that restores the saved status register.

The sequencer has four states:
- IDLE: waits for acceptance and then moves to ENTRY.
- ENTRY: after six cycles, moves to SERVE.
- SERVE: a return request moves it to RETURN.
- RETURN: after five cycles, restores the status register and moves back to IDLE.

Top module: `irq_vector_ctrl`

## Requirements
- R1: Register select 0 reads the flags, select 1 reads the enables and select 2 reads the status register, with GIE in bit 0 and LPM in bit 1. Select 3 reads zero. Source k of slot s is bit 2*s+k. A high event bit sets its flag on the next edge. A write to select 0 or 1 replaces the flags or the enables.
- R2: A maskable slot (0 to 13) requests only when one of its flags and the matching enable are both set and GIE is 1. `irq_pend` is high exactly when some slot requests.
- R3: Slots 14 and 15 request whenever an enabled flag is set, whatever the value of GIE.
- R4: The highest-numbered requesting slot is accepted. Its vector address is 0xFFE0 + 2*slot, so slot 15 gives 0xFFFE, slot 14 gives 0xFFFC and slot 0 gives 0xFFE0.
- R5: On acceptance, the flag of a single-source slot is cleared. Flags of the two-source slots (default 2, 8, 12 and 14) stay unchanged.
- R6: Acceptance happens in IDLE on an edge where `insn_done` is high and a slot requests. `vec_valid` is high only in the sixth cycle after that edge, and `in_handler` is high from the seventh cycle until return.
- R7: On acceptance, the status register is saved and then cleared (GIE=0, LPM=0). Status writes are ignored in ENTRY and RETURN.
- R8: A `reti` pulse in SERVE starts RETURN. After five cycles the saved status register is back in place and the state is IDLE.
- R9: An event setting a flag wins over a software write of 0 and over the automatic clear in the same cycle.
- R10: A two-source slot requests when either of its enabled sources is flagged.
- R11: The second source bit of a single-source slot always reads 0 in both the flag and the enable registers.
- R12: Outside IDLE, `insn_done` causes no new acceptance, even while `irq_pend` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_in | input | 32 | Event pulses, one per source bit |
| reg_sel | input | 2 | Register select: 0 flags, 1 enables, 2 status |
| reg_we | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| insn_done | input | 1 | Core is at an instruction boundary |
| reti | input | 1 | Handler requests return |
| irq_pend | output | 1 | Some slot is requesting |
| vec_valid | output | 1 | Vector address is valid this cycle |
| vec_addr | output | 16 | Vector address of the accepted slot |
| in_handler | output | 1 | Sequencer is in SERVE |

## Verification
The assertions assume that `reti` arrives only while the handler is running. They also assume that events and register writes are applied at clock edges with stable, defined values. The random stimulus keeps within this by driving all inputs on the falling edge. It raises `reti` at random, and the bench model treats a `reti` outside SERVE as having no effect. Event bursts are kept sparse and status writes are frequent. As a result, both the GIE-gated and the non-maskable paths, as well as back-to-back acceptances, occur many times.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ENTRY  = 2'd1,
        ST_SERVE  = 2'd2,
        ST_RETURN = 2'd3
    } seq_state_e;

    localparam int unsigned SR_W = 2;   // bit0 global enable, bit1 low-power
endpackage

// File: rtl/ivc_flag_bank.sv
module ivc_flag_bank #(
    parameter int unsigned SLOTS    = 16,
    parameter int unsigned SRCS     = 2,
    parameter logic [15:0] MULTI    = 16'h5104,
    parameter logic [15:0] NMI_MASK = 16'hC000,
    localparam int unsigned NSRC    = SLOTS * SRCS,
    localparam int unsigned SW      = $clog2(SLOTS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] evt_in,
    input  logic            flag_we,
    input  logic            en_we,
    input  logic [NSRC-1:0] wdata,
    input  logic            clr_vld,
    input  logic [SW-1:0]   clr_slot,
    input  logic            gie,
    output logic [NSRC-1:0] flags,
    output logic [NSRC-1:0] enables,
    output logic [SLOTS-1:0] slot_req
);
    logic [NSRC-1:0] used_mask;
    logic [NSRC-1:0] clr_mask;

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        for (genvar k = 0; k < SRCS; k++) begin : g_src
            if (k == 0 || MULTI[s]) begin : g_used
                assign used_mask[s*SRCS+k] = 1'b1;
            end else begin : g_unused
                assign used_mask[s*SRCS+k] = 1'b0;
            end
            if (k == 0 && !MULTI[s]) begin : g_autoclr
                assign clr_mask[s*SRCS+k] = clr_vld && (clr_slot == SW'(s));
            end else begin : g_noclr
                assign clr_mask[s*SRCS+k] = 1'b0;
            end
        end
        assign slot_req[s] = (|(flags[s*SRCS +: SRCS] & enables[s*SRCS +: SRCS]))
                             && (NMI_MASK[s] || gie);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags   <= '0;
            enables <= '0;
        end else begin
            flags <= (((flag_we ? wdata : flags) & ~clr_mask) | evt_in) & used_mask;
            if (en_we) enables <= wdata & used_mask;
        end
    end

    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|(evt_in & used_mask)) |=> ((flags & $past(evt_in & used_mask)) == $past(evt_in & used_mask))) // R9
        else $error("event did not set its flag");
endmodule

// File: rtl/ivc_prio_enc.sv
module ivc_prio_enc #(
    parameter int unsigned SLOTS = 16,
    localparam int unsigned SW   = $clog2(SLOTS)
) (
    input  logic [SLOTS-1:0] req,
    output logic             any,
    output logic [SW-1:0]    idx
);
    logic [SLOTS-1:0] grant;

    always_comb begin
        idx   = '0;
        grant = '0;
        for (int s = 0; s < SLOTS; s++) begin
            if (req[s]) begin
                idx   = SW'(s);
                grant = '0;
                grant[s] = 1'b1;
            end
        end
    end
    assign any = |req;

    always_comb begin
        AST_GRANT_ONEHOT: assert ($onehot0(grant)); // R4
        AST_GRANT_IN_REQ: assert ((grant & ~req) == '0); // R4
    end
endmodule

// File: rtl/ivc_seq.sv
module ivc_seq
    import ivc_pkg::*;
#(
    parameter int unsigned SLOTS     = 16,
    parameter int unsigned ENTRY_CYC = 6,
    parameter int unsigned RET_CYC   = 5,
    parameter logic [15:0] VEC_TOP   = 16'hFFFE,
    localparam int unsigned SW       = $clog2(SLOTS),
    localparam int unsigned MAXC     = (ENTRY_CYC > RET_CYC) ? ENTRY_CYC : RET_CYC,
    localparam int unsigned CNT_W    = $clog2(MAXC + 1),
    localparam logic [15:0] VEC_BASE = VEC_TOP - 16'(2 * (SLOTS - 1))
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            insn_done,
    input  logic            reti,
    input  logic            any_req,
    input  logic [SW-1:0]   best_idx,
    input  logic            sr_we,
    input  logic [SR_W-1:0] sr_wdata,
    output logic [SR_W-1:0] sr,
    output logic            accept,
    output logic            vec_valid,
    output logic [15:0]     vec_addr,
    output logic            in_handler
);
    seq_state_e state, state_nx;
    logic [CNT_W-1:0] cnt;
    logic [SW-1:0]    slot_q;
    logic [SR_W-1:0]  saved_sr;
    logic             entry_last, ret_last;

    assign entry_last = (cnt == CNT_W'(ENTRY_CYC - 1));
    assign ret_last   = (cnt == CNT_W'(RET_CYC - 1));
    assign accept     = (state == ST_IDLE) && insn_done && any_req;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (accept)     state_nx = ST_ENTRY;
            ST_ENTRY:  if (entry_last) state_nx = ST_SERVE;
            ST_SERVE:  if (reti)       state_nx = ST_RETURN;
            ST_RETURN: if (ret_last)   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            slot_q   <= '0;
            saved_sr <= '0;
            sr       <= '0;
        end else begin
            if (state_nx != state) cnt <= '0;
            else                   cnt <= cnt + 1'b1;
            if (accept) begin
                slot_q   <= best_idx;
                saved_sr <= sr;
                sr       <= '0;
            end else if (state == ST_RETURN && ret_last) begin
                sr <= saved_sr;
            end else if (sr_we && (state == ST_IDLE || state == ST_SERVE)) begin
                sr <= sr_wdata;
            end
        end
    end

    always_comb begin
        vec_valid  = (state == ST_ENTRY) && entry_last;
        vec_addr   = VEC_BASE + 16'({slot_q, 1'b0});
        in_handler = (state == ST_SERVE);
    end

    AST_VALID_THEN_SERVE: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |=> in_handler) // R6
        else $error("handler not entered after vector");
    AST_ENTRY_GIE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> (sr == '0)) // R7
        else $error("status not cleared on entry");
    AST_RETURN_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RETURN && ret_last) |=> (sr == $past(saved_sr))) // R8
        else $error("status not restored on return");
    AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> $stable(slot_q)) // R12
        else $error("slot changed while busy");
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import ivc_pkg::*;
#(
    parameter int unsigned SLOTS     = 16,
    parameter int unsigned SRCS      = 2,
    parameter logic [15:0] MULTI     = 16'h5104,
    parameter logic [15:0] NMI_MASK  = 16'hC000,
    parameter int unsigned ENTRY_CYC = 6,
    parameter int unsigned RET_CYC   = 5,
    parameter logic [15:0] VEC_TOP   = 16'hFFFE,
    localparam int unsigned NSRC     = SLOTS * SRCS,
    localparam int unsigned SW       = $clog2(SLOTS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] evt_in,
    input  logic [1:0]      reg_sel,
    input  logic            reg_we,
    input  logic [NSRC-1:0] reg_wdata,
    output logic [NSRC-1:0] reg_rdata,
    input  logic            insn_done,
    input  logic            reti,
    output logic            irq_pend,
    output logic            vec_valid,
    output logic [15:0]     vec_addr,
    output logic            in_handler
);
    logic [NSRC-1:0]  flags, enables;
    logic [SLOTS-1:0] slot_req;
    logic             any_req, accept;
    logic [SW-1:0]    best_idx;
    logic [SR_W-1:0]  sr;

    ivc_flag_bank #(.SLOTS(SLOTS), .SRCS(SRCS), .MULTI(MULTI), .NMI_MASK(NMI_MASK)) u_bank (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in),
        .flag_we(reg_we && reg_sel == 2'd0), .en_we(reg_we && reg_sel == 2'd1),
        .wdata(reg_wdata), .clr_vld(accept), .clr_slot(best_idx), .gie(sr[0]),
        .flags(flags), .enables(enables), .slot_req(slot_req)
    );

    ivc_prio_enc #(.SLOTS(SLOTS)) u_enc (
        .req(slot_req), .any(any_req), .idx(best_idx)
    );

    ivc_seq #(.SLOTS(SLOTS), .ENTRY_CYC(ENTRY_CYC), .RET_CYC(RET_CYC), .VEC_TOP(VEC_TOP)) u_seq (
        .clk(clk), .rst_n(rst_n), .insn_done(insn_done), .reti(reti),
        .any_req(any_req), .best_idx(best_idx),
        .sr_we(reg_we && reg_sel == 2'd2), .sr_wdata(reg_wdata[SR_W-1:0]),
        .sr(sr), .accept(accept), .vec_valid(vec_valid), .vec_addr(vec_addr),
        .in_handler(in_handler)
    );

    assign irq_pend = any_req;

    always_comb begin
        unique case (reg_sel)
            2'd0:    reg_rdata = flags;
            2'd1:    reg_rdata = enables;
            2'd2:    reg_rdata = NSRC'(sr);
            default: reg_rdata = '0;
        endcase
    end

    AST_PEND_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pend |-> ((flags & enables) != '0)) // R2
        else $error("pending without enabled flag");
endmodule

// File: tb/test_irq_vector_ctrl.sv
module test_irq_vector_ctrl;
    localparam logic [15:0] MULTI = 16'h5104;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic [31:0] evt_in = '0, reg_wdata = '0, reg_rdata;
    logic [1:0]  reg_sel = '0;
    logic        reg_we = 1'b0, insn_done = 1'b0, reti = 1'b0;
    logic        irq_pend, vec_valid, in_handler;
    logic [15:0] vec_addr;

    int n_chk = 0, n_bad = 0;
    bit checking = 1'b0, finished = 1'b0;

    irq_vector_ctrl i_irq_vector_ctrl (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .reg_sel(reg_sel), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .insn_done(insn_done), .reti(reti),
        .irq_pend(irq_pend), .vec_valid(vec_valid), .vec_addr(vec_addr), .in_handler(in_handler)
    );

    always #5 clk = ~clk;

    // reference model
    logic [31:0] m_flag, m_en, m_base, m_clr;
    logic [1:0]  m_sr, m_sav, m_nsr;
    logic [15:0] m_r;
    int m_st, m_cnt, m_slot;

    function automatic logic [31:0] used_mask();
        logic [31:0] m = '0;
        for (int s = 0; s < 16; s++) begin
            m[2*s] = 1'b1;
            if (MULTI[s]) m[2*s+1] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic [15:0] slot_req(logic [31:0] f, logic [31:0] e, logic [1:0] sr);
        logic [15:0] r = '0;
        for (int s = 0; s < 16; s++)
            r[s] = (|(f[2*s +: 2] & e[2*s +: 2])) && (s >= 14 || sr[0]);
        return r;
    endfunction

    function automatic int best(logic [15:0] r);
        int b = 0;
        for (int s = 0; s < 16; s++) if (r[s]) b = s;
        return b;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_flag = '0; m_en = '0; m_sr = '0; m_sav = '0;
            m_st = 0; m_cnt = 0; m_slot = 0;
        end else begin
            m_r = slot_req(m_flag, m_en, m_sr);
            m_clr = '0;
            m_nsr = m_sr;
            if (reg_we && reg_sel == 2'd2 && (m_st == 0 || m_st == 2)) m_nsr = reg_wdata[1:0];
            case (m_st)
                0: if (insn_done && m_r != 0) begin
                       m_slot = best(m_r);
                       if (!MULTI[m_slot]) m_clr[2*m_slot] = 1'b1;
                       m_sav = m_sr; m_nsr = '0; m_st = 1; m_cnt = 0;
                   end
                1: if (m_cnt == 5) m_st = 2; else m_cnt++;
                2: if (reti) begin m_st = 3; m_cnt = 0; end
                default: if (m_cnt == 4) begin m_nsr = m_sav; m_st = 0; end else m_cnt++;
            endcase
            m_base = (reg_we && reg_sel == 2'd0) ? reg_wdata : m_flag;
            m_flag = ((m_base & ~m_clr) | evt_in) & used_mask();
            if (reg_we && reg_sel == 2'd1) m_en = reg_wdata & used_mask();
            m_sr = m_nsr;
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison, between edges
    always @(posedge clk) begin
        #3;
        if (checking) begin
            logic [31:0] exp_rd;
            case (reg_sel)
                2'd0: exp_rd = m_flag;
                2'd1: exp_rd = m_en;
                2'd2: exp_rd = {30'd0, m_sr};
                default: exp_rd = '0;
            endcase
            chk("R1/R5/R7/R9/R11 rdata", reg_rdata, exp_rd);
            chk("R2/R3/R10 irq_pend", 32'(irq_pend), 32'(slot_req(m_flag, m_en, m_sr) != 0));
            chk("R6 vec_valid", 32'(vec_valid), 32'(m_st == 1 && m_cnt == 5));
            chk("R6/R8/R12 in_handler", 32'(in_handler), 32'(m_st == 2));
            if (m_st == 1 && m_cnt == 5)
                chk("R4 vec_addr", 32'(vec_addr), 32'(16'hFFE0 + 16'(2 * m_slot)));
        end
    end

    task automatic drive(logic [31:0] ev, logic we, logic [1:0] sel, logic [31:0] wd,
                         logic done, logic rt);
        @(negedge clk);
        evt_in = ev; reg_we = we; reg_sel = sel; reg_wdata = wd; insn_done = done; reti = rt;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 reset flags", reg_rdata, 32'h0);
        chk("R2 reset pend", 32'(irq_pend), 32'h0);
        checking = 1'b1;
        // R2: maskable with GIE=0 stays quiet; R3: slot 14 still requests
        drive('0, 1'b1, 2'd1, 32'hFFFF_FFFF, 1'b0, 1'b0);
        drive(32'h0000_0400, 1'b0, 2'd0, '0, 1'b0, 1'b0);   // slot 5 src0
        drive('0, 1'b0, 2'd0, '0, 1'b0, 1'b0);
        drive(32'h2000_0000, 1'b0, 2'd0, '0, 1'b0, 1'b0);   // slot 14 src1 (R10)
        drive('0, 1'b0, 2'd0, '0, 1'b1, 1'b0);              // accept slot 14, keep flag (R5)
        repeat (8) drive('0, 1'b0, 2'd0, '0, 1'b1, 1'b0);   // R12 done while busy
        drive('0, 1'b0, 2'd0, '0, 1'b0, 1'b1);              // R8 return
        repeat (6) drive('0, 1'b0, 2'd2, '0, 1'b0, 1'b0);
        // R9: event beats software clear
        drive(32'h0000_0400, 1'b1, 2'd0, 32'h0, 1'b0, 1'b0);
        drive('0, 1'b0, 2'd0, '0, 1'b0, 1'b0);
        // R4: slot 15 vector 0xFFFE; R11 unused bit write
        drive(32'h4000_0000, 1'b1, 2'd2, 32'h1, 1'b0, 1'b0);
        drive('0, 1'b1, 2'd0, 32'hFFFF_FFFF, 1'b1, 1'b0);
        repeat (8) drive('0, 1'b0, 2'd0, '0, 1'b0, 1'b0);
        drive('0, 1'b0, 2'd2, '0, 1'b0, 1'b1);
        repeat (6) drive('0, 1'b0, 2'd2, '0, 1'b0, 1'b0);
        // random phase
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] ev;
            logic we;
            ev = ($urandom % 6 == 0) ? (32'(1) << ($urandom % 32)) : 32'h0;
            we = ($urandom % 5 == 0);
            drive(ev, we, 2'($urandom), (2'($urandom) == 0) ? 32'h0 : $urandom,
                  ($urandom % 3 != 0), ($urandom % 4 == 0));
        end
        drive('0, 1'b0, 2'd0, '0, 1'b0, 1'b0);
        @(negedge clk);
        checking = 1'b0;
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule